// File: doc/BRIEF.md
# Read-Only Cache with Selectable Associativity

This block is a small read-only cache. It sits between a processor-side read port and a main-memory block-read port. It holds eight lines of sixteen bytes each. One parameter groups those eight lines into sets of 1, 2, 4 or 8 ways, which gives a direct-mapped, 2-way, 4-way or fully associative organisation. The total capacity stays the same in every case.

A request compares the tags of every way in the addressed set in parallel. On a hit the 32-bit word comes back on the next cycle. On a miss the block is fetched from memory, which may take any number of cycles. The fetched block goes into a way chosen by the replacement logic, and then the word is returned. The replacement logic takes the lowest-numbered empty way first. Once the set is full it uses a rotating pointer kept for each set. Two running counters report how many lookups hit and how many missed.

Top module: `assoc_cache`

## Requirements
- R1: After reset every line is invalid: `cpu_ready` is 1, `cpu_rvalid` and `mem_req` are 0, both counters read 0, and the first access to any block misses.
- R2: A byte address splits into these fields:
  - Bits [3:0] are the offset within the line. Bits [3:2] pick the word, and word k is bits [32k+31:32k] of the line.
  - The set is the block number (address bits [11:4]) modulo 8/WAYS.
  - The tag is the block number divided by 8/WAYS.
  - At most one way of a set ever matches.
- R3: A hit drives `cpu_rvalid` high with the addressed word exactly one cycle after the acceptance edge, for one cycle only, and never raises `mem_req`.
- R4: On a miss, `mem_req` rises two cycles after acceptance with `mem_addr` equal to the block number. Both hold steady until `mem_fill_valid` is sampled.
- R5: The cycle after `mem_fill_valid` is sampled, `cpu_rvalid` is high with the addressed word taken from the fill. `cpu_ready` returns on the following cycle.
- R6: `cpu_ready` is high only when the cache is idle. It drops on the cycle after a request is accepted, so only one request is outstanding at a time.
- R7: A miss fills the lowest-numbered invalid way of its set. If the set is full, it fills the way named by that set's rotating pointer. Every fill moves the pointer to (filled way + 1) mod WAYS.
- R8: Alternating reads of blocks 0x000 and 0x080, starting from empty, miss on every one of eight accesses when WAYS=1. With WAYS of 2 or more, only the first two of those accesses miss.
- R9: `hit_count` increments once per hit and `miss_count` once per miss, at the end of the lookup cycle.
- R10: With WAYS=8, any eight distinct blocks are all held at once, even blocks that share the same low block-number bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Read request, accepted when `cpu_ready` is high |
| cpu_word_addr | input | ADDR_W-2 | Word address (byte address bits [ADDR_W-1:2]) |
| cpu_ready | output | 1 | Cache idle and able to accept a request |
| cpu_rvalid | output | 1 | Read data valid, one-cycle pulse |
| cpu_rdata | output | 32 | Read data word |
| mem_req | output | 1 | Block fetch request, held until the fill arrives |
| mem_addr | output | ADDR_W-4 | Block number to fetch |
| mem_fill_valid | input | 1 | Fill data present this cycle |
| mem_fill_data | input | 128 | Whole 16-byte line, word 0 in the low bits |
| hit_count | output | CNT_W | Lookups that hit |
| miss_count | output | CNT_W | Lookups that missed |

## Verification
Timing is counted from the edge that accepts a request. A hit's data is due in the first cycle after that edge, and `mem_req` for a miss is due in the second cycle. The missed word is due in the cycle after the edge that samples the fill, and `cpu_ready` returns one cycle later. The counters are settled once `cpu_ready` is back.

The bench drives every input at falling edges and samples each of these outputs at the falling edge inside the cycle where it is due. It does this for all four way counts side by side. A behavioural model of tags, valid bits and rotation pointers decides in advance whether each access should hit or miss.

// File: rtl/cache_pkg.sv
package cache_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LOOK,
      ST_MISS,
      ST_RESP
   } cache_state_e;
endpackage

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
   parameter int WAYS  = 2,
   parameter int TAG_W = 6,
   parameter int WAY_W = 1
) (
   input  logic [WAYS*TAG_W-1:0] set_tags,
   input  logic [WAYS-1:0]       set_valid,
   input  logic [TAG_W-1:0]      look_tag,
   output logic [WAYS-1:0]       match,
   output logic                  hit,
   output logic [WAY_W-1:0]      hit_way
);
   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = set_valid[w] && (set_tags[w*TAG_W +: TAG_W] == look_tag);
   end

   always_comb begin
      hit     = |match;
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (match[w]) hit_way = WAY_W'(w);
      end
   end
endmodule

// File: rtl/cache_victim_pick.sv
module cache_victim_pick #(
   parameter int WAYS  = 2,
   parameter int WAY_W = 1
) (
   input  logic [WAYS-1:0]  set_valid,
   input  logic [WAY_W-1:0] rr_ptr,
   output logic [WAY_W-1:0] victim
);
   logic found;

   always_comb begin
      victim = rr_ptr;
      found  = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
         if (!set_valid[w] && !found) begin
            victim = WAY_W'(w);
            found  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/assoc_cache.sv
module assoc_cache
   import cache_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int LINES      = 8,
   parameter int LINE_BYTES = 16,
   parameter int WAYS       = 2,
   parameter int CNT_W      = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cpu_req,
   input  logic [ADDR_W-1:2]          cpu_word_addr,
   output logic                       cpu_ready,
   output logic                       cpu_rvalid,
   output logic [31:0]                cpu_rdata,
   output logic                       mem_req,
   output logic [ADDR_W-1:$clog2(LINE_BYTES)] mem_addr,
   input  logic                       mem_fill_valid,
   input  logic [LINE_BYTES*8-1:0]    mem_fill_data,
   output logic [CNT_W-1:0]           hit_count,
   output logic [CNT_W-1:0]           miss_count
);
   localparam int WORD_W = 32;
   localparam int LINE_W = LINE_BYTES * 8;
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int WSEL_W = OFF_W - 2;
   localparam int SETS   = LINES / WAYS;
   localparam int IDX_W  = (SETS > 1) ? $clog2(SETS) : 0;
   localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1;
   localparam int PTR_N  = 2 ** SET_W;
   localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
   localparam int LIDX_W = (LINES > 1) ? $clog2(LINES) : 1;
   localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;

   // elaboration-time parameter checks
   if ((WAYS & (WAYS - 1)) != 0 || WAYS < 1 || WAYS > LINES) begin : g_bad_ways
      $error("WAYS must be a power of two no larger than LINES");
   end
   if ((LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two");
   end
   if (LINE_BYTES < 8 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 8");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W too small for this geometry");
   end

   cache_state_e             state_q;
   logic [ADDR_W-1:2]        addr_q;
   logic [WAY_W-1:0]         victim_q;
   logic [LINES-1:0]         valid_q;
   logic [TAG_W-1:0]         tag_q  [LINES];
   logic [LINE_W-1:0]        data_q [LINES];
   logic [WAY_W-1:0]         ptr_q  [PTR_N];

   logic [SET_W-1:0]         set_idx;
   logic [TAG_W-1:0]         req_tag;
   logic [WSEL_W-1:0]        word_sel;
   logic [WAYS*TAG_W-1:0]    set_tags;
   logic [WAYS-1:0]          set_valid;
   logic [WAYS-1:0]          match;
   logic                     hit;
   logic [WAY_W-1:0]         hit_way;
   logic [WAY_W-1:0]         victim;
   logic [LIDX_W-1:0]        rd_line;
   logic [LIDX_W-1:0]        fill_line;

   function automatic logic [LIDX_W-1:0] line_of(input logic [SET_W-1:0] s,
                                                 input logic [WAY_W-1:0] w);
      line_of = LIDX_W'(int'(s) * WAYS + int'(w));
   endfunction

   // address decode of the held request
   if (SETS > 1) begin : g_indexed
      assign set_idx = addr_q[OFF_W +: IDX_W];
   end else begin : g_single_set
      assign set_idx = '0;
   end
   assign req_tag  = addr_q[ADDR_W-1 -: TAG_W];
   assign word_sel = addr_q[OFF_W-1:2];

   for (genvar w = 0; w < WAYS; w++) begin : g_gather
      assign set_tags[w*TAG_W +: TAG_W] = tag_q[line_of(set_idx, WAY_W'(w))];
      assign set_valid[w]               = valid_q[line_of(set_idx, WAY_W'(w))];
   end

   cache_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
      .set_tags (set_tags),
      .set_valid(set_valid),
      .look_tag (req_tag),
      .match    (match),
      .hit      (hit),
      .hit_way  (hit_way)
   );

   cache_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
      .set_valid(set_valid),
      .rr_ptr   (ptr_q[set_idx]),
      .victim   (victim)
   );

   assign fill_line = line_of(set_idx, victim_q);
   assign rd_line   = (state_q == ST_RESP) ? fill_line : line_of(set_idx, hit_way);

   // control
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         addr_q     <= '0;
         victim_q   <= '0;
         valid_q    <= '0;
         hit_count  <= '0;
         miss_count <= '0;
         for (int s = 0; s < PTR_N; s++) ptr_q[s] <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (cpu_req) begin
               addr_q  <= cpu_word_addr;
               state_q <= ST_LOOK;
            end
            ST_LOOK: if (hit) begin
               hit_count <= hit_count + CNT_W'(1);
               state_q   <= ST_IDLE;
            end else begin
               miss_count <= miss_count + CNT_W'(1);
               victim_q   <= victim;
               state_q    <= ST_MISS;
            end
            ST_MISS: if (mem_fill_valid) begin
               valid_q[fill_line] <= 1'b1;
               ptr_q[set_idx]     <= (victim_q == WAY_W'(WAYS - 1)) ? '0
                                                                    : victim_q + WAY_W'(1);
               state_q            <= ST_RESP;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // line storage, no reset needed behind the valid bits
   always_ff @(posedge clk) begin
      if (state_q == ST_MISS && mem_fill_valid) begin
         tag_q[fill_line]  <= req_tag;
         data_q[fill_line] <= mem_fill_data;
      end
   end

   assign cpu_ready  = (state_q == ST_IDLE);
   assign cpu_rvalid = ((state_q == ST_LOOK) && hit) || (state_q == ST_RESP);
   assign cpu_rdata  = data_q[rd_line][{word_sel, 5'd0} +: WORD_W];
   assign mem_req    = (state_q == ST_MISS);
   assign mem_addr   = addr_q[ADDR_W-1:OFF_W];

   // R2
   single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LOOK) |-> $onehot0(match));

   // R3
   rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rvalid |=> (!cpu_rvalid && cpu_ready));

   // R4
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_fill_valid) |=> (mem_req && $stable(mem_addr)));

   // R6
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_ready) |=> !cpu_ready);

   // R9
   miss_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> (miss_count == $past(miss_count) + CNT_W'(1)));

   // R9
   hit_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rvalid && !$past(mem_req)) |=> (hit_count == $past(hit_count) + CNT_W'(1)));
endmodule

// File: tb/assoc_cache_bench.sv
module assoc_cache_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   int   n_tests = 0;
   int   n_fail  = 0;
   bit   done [4];

   always #10 clk = ~clk;

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [127:0] line_for(input int blk);
      logic [127:0] l;
      for (int k = 0; k < 4; k++) l[32*k +: 32] = 32'hD000_0000 | 32'(blk * 16 + k * 4);
      return l;
   endfunction

   for (genvar g = 0; g < 4; g++) begin : g_cfg
      localparam int W = 1 << g;
      localparam int S = 8 / W;

      logic        req = 1'b0;
      logic [11:2] waddr = '0;
      logic        ready, rvalid, mreq;
      logic [31:0] rdata;
      logic [11:4] maddr;
      logic        fv = 1'b0;
      logic [127:0] fdata = '0;
      logic [15:0] hc, mc;

      int mtag [8];
      bit mval [8];
      int mptr [8];
      int exp_h = 0;
      int exp_m = 0;

      assoc_cache #(.WAYS(W)) u_assoc_cache (
         .clk(clk), .rst_n(rst_n), .cpu_req(req), .cpu_word_addr(waddr),
         .cpu_ready(ready), .cpu_rvalid(rvalid), .cpu_rdata(rdata),
         .mem_req(mreq), .mem_addr(maddr), .mem_fill_valid(fv),
         .mem_fill_data(fdata), .hit_count(hc), .miss_count(mc)
      );

      task automatic access(input int a, input int dly);
         int blk  = a >> 4;
         int set  = blk % S;
         int tg   = blk / S;
         bit hit  = 0;
         int vic  = -1;
         logic [31:0] ew = 32'hD000_0000 | 32'(a & 'hFFC);
         logic [11:0] av = 12'(a);
         for (int w = 0; w < W; w++)
            if (mval[set*W+w] && mtag[set*W+w] == tg) hit = 1;
         @(negedge clk);
         check(ready == 1'b1, $sformatf("R6 idle ready ways=%0d", W), 64'(ready), 1);
         req = 1'b1; waddr = av[11:2];
         @(negedge clk);
         req = 1'b0;
         check(ready == 1'b0, $sformatf("R6 busy ways=%0d", W), 64'(ready), 0);
         check(rvalid == hit, $sformatf("R7 hit/miss a=%0h ways=%0d", a, W), 64'(rvalid), 64'(hit));
         if (hit) begin
            exp_h++;
            check(rdata == ew, $sformatf("R3 R2 hit data ways=%0d", W), 64'(rdata), 64'(ew));
            check(mreq == 1'b0, $sformatf("R3 no fetch ways=%0d", W), 64'(mreq), 0);
         end else begin
            exp_m++;
            for (int w = W - 1; w >= 0; w--) if (!mval[set*W+w]) vic = w;
            if (vic < 0) vic = mptr[set];
            @(negedge clk);
            check(mreq == 1'b1 && maddr == 8'(blk), $sformatf("R4 fetch ways=%0d", W),
                  {mreq, 8'(maddr)}, {1'b1, 8'(blk)});
            for (int d = 0; d < dly; d++) begin
               @(negedge clk);
               check(mreq == 1'b1 && rvalid == 1'b0 && maddr == 8'(blk),
                     $sformatf("R4 hold ways=%0d", W), {mreq, rvalid}, 2'b10);
            end
            fv = 1'b1; fdata = line_for(blk);
            @(negedge clk);
            fv = 1'b0;
            check(rvalid == 1'b1 && rdata == ew, $sformatf("R5 fill data ways=%0d", W),
                  {rvalid, rdata}, {1'b1, ew});
            mval[set*W+vic] = 1;
            mtag[set*W+vic] = tg;
            mptr[set]       = (vic + 1) % W;
         end
         @(negedge clk);
         check(rvalid == 1'b0 && ready == 1'b1, $sformatf("R5 R3 back idle ways=%0d", W),
               {rvalid, ready}, 2'b01);
         check(hc == 16'(exp_h) && mc == 16'(exp_m), $sformatf("R9 counters ways=%0d", W),
               {hc, mc}, {16'(exp_h), 16'(exp_m)});
      endtask

      initial begin
         int m0;
         for (int i = 0; i < 8; i++) begin mval[i] = 0; mtag[i] = 0; mptr[i] = 0; end
         wait (rst_n == 1'b1);
         @(negedge clk);
         check(ready == 1'b1 && rvalid == 1'b0 && mreq == 1'b0 && hc == 0 && mc == 0,
               $sformatf("R1 reset state ways=%0d", W), {ready, rvalid, mreq, hc, mc},
               {1'b1, 1'b0, 1'b0, 32'd0});
         // R8: alternating pair of conflicting blocks
         for (int i = 0; i < 8; i++) access((i % 2) ? 'h084 : 'h008, 1);
         check(mc == ((W == 1) ? 16'd8 : 16'd2), $sformatf("R8 alternation ways=%0d", W),
               64'(mc), (W == 1) ? 8 : 2);
         // R7: many blocks sharing set 0, then revisit
         for (int k = 0; k < 10; k++) access(k * 'h80 + 4 * (k % 4), k % 3);
         for (int k = 0; k < 10; k++) access(((9 - k) * 'h80) + 12, 0);
         // R10: eight blocks with equal low block bits
         m0 = exp_m;
         for (int r = 0; r < 2; r++)
            for (int k = 0; k < 8; k++) access('h800 + k * 'h80, 2);
         if (W == 8)
            check(exp_m - m0 == 8, "R10 fully associative keeps eight", 64'(exp_m - m0), 8);
         // mixed pattern
         for (int i = 0; i < 40; i++) access((((i * 7 + 3) % 20) << 4) | ((i % 4) << 2), i % 4);
         done[g] = 1'b1;
      end
   end

   initial begin
      bit all_done = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      for (int c = 0; c < 100000 && !all_done; c++) begin
         @(posedge clk);
         all_done = done[0] && done[1] && done[2] && done[3];
      end
      if (!all_done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
      end
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule